// File: doc/BRIEF.md
# Collision Indicator Controller with Jabber Guard and Heartbeat

This block decides when a coaxial transceiver raises its collision indication towards the attached station, and produces the gated square tone that carries it. Three sources feed the indication: a collision flag from the analog threshold stage, a jabber guard that trips after transmit activity has lasted too long, and a heartbeat burst that follows every transmission when it is enabled. The tone is a divided copy of the sample clock. With the default divide of 10 and a 100 MHz clock it is 10 MHz at 50% duty.

The jabber guard also drives a transmitter-disable output. Once tripped, it holds until the transmit input has stayed quiet for a full unjab interval. Any activity during that interval starts the wait again. All durations are counted in clock cycles through parameters, and their defaults are short so that a bench run stays brief.

Top module: `coll_sig_ctrl`

## Requirements
- R1: `tx_inhibit` rises once `tx_valid` has been sampled high on JAB_LIMIT consecutive rising edges. It rises in the cycle after the last of those edges. A run of JAB_LIMIT-1 high samples followed by a low one leaves `tx_inhibit` low.
- R2: While `tx_inhibit` is high, `coll_active` is high and `coll_tone` carries the tone.
- R3: After `tx_inhibit` rises, it falls once `tx_valid` has been sampled low on UNJAB consecutive edges, visible after the last of them. A single high sample during the wait restarts the count from zero.
- R4: With `hb_en` high and no jabber, a one-cycle `tx_end` pulse sampled at edge e makes `coll_active` high from edge e+HB_DELAY for exactly HB_WIDTH cycles.
- R5: With `hb_en` low when `tx_end` is sampled, no burst follows. Lowering `hb_en` during a pending or running burst ends it at the next edge.
- R6: `coll_active` is high exactly when `coll_det` is high, the jabber guard is tripped or a heartbeat burst runs. `coll_det` acts in the same cycle. `coll_tone` is 0 whenever `coll_active` is low.
- R7: The tone has a period of DIV cycles and is high for DIV/2 of them. Over any DIV*4 consecutive cycles of indication it shows 4 rising transitions and is high for DIV*2 cycles.
- R8: A `tx_end` pulse sampled while the jabber guard is tripped starts no heartbeat, including after the guard releases.
- R9: While `rst_n` is low on an edge, the guard and the heartbeat return to idle. After reset all three outputs are low while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (100 MHz for a 10 MHz tone at DIV=10) |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit activity from the squelch stage |
| tx_end | input | 1 | One-cycle pulse at the end of a transmission |
| coll_det | input | 1 | Collision flag from the threshold comparator |
| hb_en | input | 1 | Heartbeat enable |
| coll_active | output | 1 | Collision indication is on |
| coll_tone | output | 1 | Gated square tone for the collision line driver |
| tx_inhibit | output | 1 | Disables the transmit driver while jabbing |

## Verification
Two pairs of sources can coincide. An external collision can overlap a running heartbeat burst. The bench raises `coll_det` in the middle of a burst and holds it past the burst's last cycle. It then expects `coll_active` to stay high across the burst end and to drop in the very cycle that `coll_det` is released. The second pair is an end-of-transmit pulse and a tripped jabber guard. The bench drops `tx_valid` and pulses `tx_end` in the same cycle while the guard is tripped. The unjab time is shorter than the heartbeat delay plus width, so a wrongly started burst would still be running after release, where the bench expects the indication to be off.

// File: rtl/coll_sig_pkg.sv
// Package: shared types for the collision indicator controller.
// Assumes: nothing beyond the standard language.
package coll_sig_pkg;

    // Heartbeat sequencer states
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_BURST = 2'd2
    } hb_state_t;

    // Width needed to count 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/coll_tone_gen.sv
// Module: coll_tone_gen
// Free-running divider that makes a square tone of period DIV cycles,
// high for the first DIV/2 counts of each period.
// Assumes: DIV is even and at least 2; the tone runs from reset release.
module coll_tone_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tone
);
    import coll_sig_pkg::*;

    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] phase_q;

    // Advance the phase counter and wrap at the end of a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tone is high in the first half of each period
    always_comb begin
        tone = (phase_q < HALF);
    end

endmodule

// File: rtl/coll_jabber.sv
// Module: coll_jabber
// Jabber guard. Counts consecutive active samples of tx_valid. After
// JAB_LIMIT of them it latches. It releases only after UNJAB consecutive
// quiet samples; any active sample during the wait restarts it.
// Assumes: tx_valid is synchronous to clk; JAB_LIMIT and UNJAB >= 2.
module coll_jabber #(
    parameter int JAB_LIMIT = 200,
    parameter int UNJAB     = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    output logic jabbed
);
    import coll_sig_pkg::*;

    localparam int JW = cnt_width(JAB_LIMIT);
    localparam int UW = cnt_width(UNJAB);
    localparam logic [JW-1:0] JAB_LAST = JW'(JAB_LIMIT - 1);
    localparam logic [UW-1:0] UNJ_LAST = UW'(UNJAB - 1);

    logic [JW-1:0] act_cnt_q;
    logic [UW-1:0] quiet_cnt_q;
    logic          jabbed_q;

    // Activity counter: runs while active and not latched
    always_ff @(posedge clk) begin
        if (!rst_n || jabbed_q || !tx_valid) begin
            act_cnt_q <= '0;
        end else if (act_cnt_q != JAB_LAST) begin
            act_cnt_q <= act_cnt_q + 1'b1;
        end
    end

    // Quiet counter: runs only while latched and idle
    always_ff @(posedge clk) begin
        if (!rst_n || !jabbed_q || tx_valid) begin
            quiet_cnt_q <= '0;
        end else if (quiet_cnt_q != UNJ_LAST) begin
            quiet_cnt_q <= quiet_cnt_q + 1'b1;
        end
    end

    // Latch: set at the end of the activity limit, clear at the end of the quiet wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jabbed_q <= 1'b0;
        end else if (!jabbed_q && tx_valid && act_cnt_q == JAB_LAST) begin
            jabbed_q <= 1'b1;
        end else if (jabbed_q && !tx_valid && quiet_cnt_q == UNJ_LAST) begin
            jabbed_q <= 1'b0;
        end
    end

    assign jabbed = jabbed_q;

endmodule

// File: rtl/coll_heartbeat.sv
// Module: coll_heartbeat
// Heartbeat sequencer. A tx_end pulse, while enabled and not jabbing,
// starts a wait of HB_DELAY cycles and then a burst of HB_WIDTH cycles.
// A new pulse restarts the wait. Dropping hb_en cancels at the next edge.
// Assumes: tx_end is a one-cycle pulse; HB_DELAY and HB_WIDTH >= 1.
module coll_heartbeat #(
    parameter int HB_DELAY = 110,
    parameter int HB_WIDTH = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_end,
    input  logic hb_en,
    input  logic jabbed,
    output logic burst
);
    import coll_sig_pkg::*;

    localparam int HB_MAX = (HB_DELAY > HB_WIDTH) ? HB_DELAY : HB_WIDTH;
    localparam int HW     = cnt_width(HB_MAX);
    localparam logic [HW-1:0] DLY_LAST = HW'(HB_DELAY - 1);
    localparam logic [HW-1:0] WID_LAST = HW'(HB_WIDTH - 1);

    hb_state_t     state_q;
    logic [HW-1:0] cnt_q;
    logic          start;

    // A heartbeat may start only when enabled and the guard is idle
    always_comb begin
        start = tx_end && hb_en && !jabbed;
    end

    // Sequence idle -> wait -> burst -> idle with one shared counter
    always_ff @(posedge clk) begin
        if (!rst_n || !hb_en) begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= HB_WAIT;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                HB_WAIT: begin
                    if (cnt_q == DLY_LAST) begin
                        state_q <= HB_BURST;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                HB_BURST: begin
                    if (cnt_q == WID_LAST) begin
                        state_q <= HB_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= HB_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign burst = (state_q == HB_BURST);

endmodule

// File: rtl/coll_sig_ctrl.sv
// Module: coll_sig_ctrl (top)
// Merges the external collision flag, the jabber guard and the heartbeat
// into one indication, gates the divided tone with it and drives the
// transmitter disable from the guard.
// Assumes: every input is synchronous to clk; coll_det is already filtered.
module coll_sig_ctrl #(
    parameter int DIV       = 10,
    parameter int JAB_LIMIT = 200,
    parameter int UNJAB     = 500,
    parameter int HB_DELAY  = 110,
    parameter int HB_WIDTH  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_end,
    input  logic coll_det,
    input  logic hb_en,
    output logic coll_active,
    output logic coll_tone,
    output logic tx_inhibit
);

    logic tone;
    logic jabbed;
    logic burst;

    coll_tone_gen #(.DIV(DIV)) u_tone (
        .clk   (clk),
        .rst_n (rst_n),
        .tone  (tone)
    );

    coll_jabber #(.JAB_LIMIT(JAB_LIMIT), .UNJAB(UNJAB)) u_jab (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .jabbed   (jabbed)
    );

    coll_heartbeat #(.HB_DELAY(HB_DELAY), .HB_WIDTH(HB_WIDTH)) u_hb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_end (tx_end),
        .hb_en  (hb_en),
        .jabbed (jabbed),
        .burst  (burst)
    );

    // Indication from any source; the tone passes only while it is on
    always_comb begin
        coll_active = coll_det | jabbed | burst;
        coll_tone   = coll_active & tone;
        tx_inhibit  = jabbed;
    end

endmodule

// File: rtl/coll_sig_ctrl_chk.sv
// Module: coll_sig_ctrl_chk
// Property checker bound to coll_sig_ctrl; observes ports only.
// Assumes: same parameters as the bound instance.
module coll_sig_ctrl_chk #(
    parameter int DIV = 10
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic coll_det,
    input logic hb_en,
    input logic coll_active,
    input logic coll_tone,
    input logic tx_inhibit
);
    localparam int RW = $clog2(DIV + 2);
    localparam logic [RW-1:0] RMAX = RW'(DIV + 1);

    logic [RW-1:0] hi_run_q;

    // Length of the current high run of the tone, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !coll_tone) begin
            hi_run_q <= '0;
        end else if (hi_run_q != RMAX) begin
            hi_run_q <= hi_run_q + 1'b1;
        end
    end

    assert_tone_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coll_tone |-> coll_active);

    assert_inhibit_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> $past(tx_valid));

    assert_inhibit_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_inhibit) |-> !$past(tx_valid));

    assert_hb_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_active && !coll_det && !tx_inhibit) |-> $past(hb_en));

    assert_tone_high_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= RW'(DIV / 2));

endmodule

bind coll_sig_ctrl coll_sig_ctrl_chk #(.DIV(DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .coll_det    (coll_det),
    .hb_en       (hb_en),
    .coll_active (coll_active),
    .coll_tone   (coll_tone),
    .tx_inhibit  (tx_inhibit)
);

// File: tb/tb_coll_sig_ctrl.sv
// Scoreboard bench: scenario tasks queue expected (cycle, active, inhibit)
// items; a monitor at the falling edge pops and compares them.
module tb_coll_sig_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 10;
    localparam int J   = 40;
    localparam int U   = 60;
    localparam int D   = 30;
    localparam int W   = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic tx_end = 1'b0;
    logic coll_det = 1'b0;
    logic hb_en = 1'b1;
    logic coll_active, coll_tone, tx_inhibit;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    typedef struct {
        int    cyc;
        logic  act;
        logic  inh;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t it;

    coll_sig_ctrl #(.DIV(DIV), .JAB_LIMIT(J), .UNJAB(U), .HB_DELAY(D), .HB_WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_end(tx_end),
        .coll_det(coll_det), .hb_en(hb_en), .coll_active(coll_active),
        .coll_tone(coll_tone), .tx_inhibit(tx_inhibit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare due expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            it = sb_q.pop_front();
            checks++;
            if (it.cyc != cyc || coll_active !== it.act || tx_inhibit !== it.inh) begin
                failures++;
                $display("FAIL %s cyc=%0d/%0d active=%b/%b inhibit=%b/%b (actual/expected)",
                         it.tag, cyc, it.cyc, coll_active, it.act, tx_inhibit, it.inh);
            end
        end
    end

    task automatic push_exp(input int c, input logic a, input logic i, input string t);
        exp_t e;
        e.cyc = c; e.act = a; e.inh = i; e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic drain();
        while (sb_q.size() > 0) step();
        step(2);
    endtask

    task automatic pulse_end();
        tx_end = 1'b1;
        step();
        tx_end = 1'b0;
    endtask

    // Sample the tone on 41 falling edges; expect 4 rises and 20 highs in the last 40
    task automatic check_tone(input int exp_hi, input int exp_rise, input string tag);
        int hi = 0;
        int rise = 0;
        logic prev;
        @(negedge clk);
        prev = coll_tone;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (coll_tone) hi++;
            if (coll_tone && !prev) rise++;
            prev = coll_tone;
        end
        checks++;
        if (hi != exp_hi || rise != exp_rise) begin
            failures++;
            $display("FAIL %s tone highs=%0d/%0d rises=%0d/%0d (actual/expected)",
                     tag, hi, exp_hi, rise, exp_rise);
        end
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, m, m2, e, k;
        // R9: reset state
        step(4);
        rst_n = 1'b1;
        n = cyc;
        push_exp(n + 1, 1'b0, 1'b0, "R9 reset idle");
        push_exp(n + 5, 1'b0, 1'b0, "R9 idle after reset");
        drain();
        check_tone(0, 0, "R9 tone silent after reset");

        // R1: one sample short of the limit does not trip
        n = cyc;
        tx_valid = 1'b1;
        push_exp(n + J - 1, 1'b0, 1'b0, "R1 short run no trip");
        step(J - 1);
        tx_valid = 1'b0;
        push_exp(cyc + 2, 1'b0, 1'b0, "R1 short run stays clear");
        drain();

        // R1, R2, R3: trip, tone during jabber, clean release
        n = cyc;
        tx_valid = 1'b1;
        push_exp(n + J - 1, 1'b0, 1'b0, "R1 before trip");
        push_exp(n + J, 1'b1, 1'b1, "R1 R2 trip");
        step(J + 2);
        check_tone(20, 4, "R2 R7 tone while jabbing");
        tx_valid = 1'b0;
        m = cyc;
        push_exp(m + U - 1, 1'b1, 1'b1, "R3 still latched");
        push_exp(m + U, 1'b0, 1'b0, "R3 release");
        drain();

        // R3: activity during the quiet wait restarts it
        n = cyc;
        tx_valid = 1'b1;
        push_exp(n + J, 1'b1, 1'b1, "R1 trip again");
        step(J + 2);
        tx_valid = 1'b0;
        m = cyc;
        step(20);
        tx_valid = 1'b1;
        step();
        tx_valid = 1'b0;
        m2 = cyc;
        push_exp(m + U, 1'b1, 1'b1, "R3 restart holds latch");
        push_exp(m2 + U - 1, 1'b1, 1'b1, "R3 restarted wait");
        push_exp(m2 + U, 1'b0, 1'b0, "R3 release after restart");
        drain();

        // R4: heartbeat timing
        e = cyc;
        push_exp(e + D, 1'b0, 1'b0, "R4 before burst");
        push_exp(e + 1 + D, 1'b1, 1'b0, "R4 burst start");
        push_exp(e + D + W, 1'b1, 1'b0, "R4 burst last");
        push_exp(e + 1 + D + W, 1'b0, 1'b0, "R4 burst end");
        pulse_end();
        drain();

        // R5: disabled heartbeat never starts
        hb_en = 1'b0;
        e = cyc;
        push_exp(e + 1 + D, 1'b0, 1'b0, "R5 disabled no burst");
        push_exp(e + D + 10, 1'b0, 1'b0, "R5 disabled no burst later");
        pulse_end();
        drain();
        hb_en = 1'b1;
        step(2);

        // R5: dropping enable cancels a running burst
        e = cyc;
        push_exp(e + 1 + D + 2, 1'b1, 1'b0, "R5 burst running");
        pulse_end();
        step(D + 4);
        k = cyc;
        hb_en = 1'b0;
        push_exp(k + 1, 1'b0, 1'b0, "R5 burst cancelled");
        drain();
        hb_en = 1'b1;
        step(2);

        // R8: end of transmit while jabbing starts no heartbeat
        tx_valid = 1'b1;
        step(J + 2);
        tx_valid = 1'b0;
        e = cyc;
        push_exp(e + U - 1, 1'b1, 1'b1, "R8 latched before release");
        push_exp(e + U, 1'b0, 1'b0, "R8 release no burst");
        push_exp(e + U + 5, 1'b0, 1'b0, "R8 no burst after release");
        pulse_end();
        drain();

        // R6, R7: external collision acts at once and carries the tone
        coll_det = 1'b1;
        push_exp(cyc, 1'b1, 1'b0, "R6 collision on");
        step();
        check_tone(20, 4, "R7 tone period and duty");
        coll_det = 1'b0;
        push_exp(cyc, 1'b0, 1'b0, "R6 collision off");
        step();
        check_tone(0, 0, "R6 tone silent when inactive");

        // R6: collision overlapping a heartbeat burst
        e = cyc;
        pulse_end();
        step(D + 10);
        coll_det = 1'b1;
        push_exp(e + 1 + D + W + 2, 1'b1, 1'b0, "R6 collision holds past burst");
        step(W);
        k = cyc;
        coll_det = 1'b0;
        push_exp(k, 1'b0, 1'b0, "R6 release after overlap");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule